// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures the period of one of three slow clocks against a fast reference clock. The selected slow clock is synchronized into the reference domain, and its rising edges are detected there. Counting begins at the first detected slow edge after a start. The block then reports how many reference cycles elapsed while a programmed number of slow periods went by. Software divides this value by the slow cycle count to find the slow clock period in reference cycles.

Two modes are available. A one-shot measurement starts on a rising edge of the one-shot start input and raises a sticky ready flag when it completes. In cycling mode, windows run back to back and a valid pulse marks each new result. Cycling is the default, because its control input is active-low: with every control input at zero after reset, cycling runs.

A watchdog aborts any measurement that takes longer than sixteen times the timeout threshold. It sets a timeout flag and returns the counting logic to idle. A short threshold therefore ends a long cycling window quickly, and the next measurement is unaffected.

Top module: `slow_clk_cal`

## Requirements
- R1: A completed measurement reports P × N in `cal_value`, where P is the slow period in reference cycles and N is `max_cycles`.
- R2: A one-shot measurement ends by setting `cal_ready`. The flag stays high, and the block stays idle, until the next start.
- R3: After reset, with `cycling_off` low, measurements repeat on their own without any start pulse.
- R4: While `cycling_off` is high, a one-shot run starts only on a 0-to-1 transition of `start_oneshot`. Holding the input high does not restart the run.
- R5: In cycling mode, `cycle_valid` is a one-cycle pulse for each new value. Windows follow each other back to back, and every window gives the full P × N. No pulse appears once `cycling_off` is high.
- R6: If a measurement runs for more than `timeout_thres` × 16 reference cycles, `cal_timeout` is set, the run is abandoned and `cal_ready` stays low. The next start clears the flag and gives a correct result.
- R7: A timeout in cycling mode stops cycling and keeps `cal_timeout` high until cycling is enabled again, which is a falling edge on `cycling_off`.
- R8: `src_sel` values 0, 1 and 2 measure `slow_clk[0]`, `slow_clk[1]` and `slow_clk[2]`. The value 3 selects no clock, so a run with it can only end by timeout.
- R9: A `max_cycles` value of zero never completes. Such a run ends only through the timeout.
- R10: The reference count saturates at all ones and never wraps.
- R11: During reset, all flags and `cal_value` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 3 | The three slow clocks that can be measured |
| src_sel | input | 2 | Source select (0..2; 3 selects no clock) |
| max_cycles | input | MAX_W | Number of slow periods per window |
| start_oneshot | input | 1 | One-shot start; acts on its rising edge |
| cycling_off | input | 1 | High disables continuous measurement |
| timeout_thres | input | THR_W | Timeout threshold, scaled by 16 |
| cal_ready | output | 1 | One-shot result available (sticky) |
| cycle_valid | output | 1 | One-cycle pulse for each cycling result |
| cal_timeout | output | 1 | Last run was aborted by the timeout |
| cal_value | output | CNT_W | Captured reference count |

## Verification
The hardest case to reach is a continuous run stuck on a window far longer than its timeout. The case must show that the abort holds, that no stray valid pulse appears, and that cycling resumes cleanly afterwards. The bench reaches it in three steps. It first enables cycling with a thousand-period window and a threshold of one. It then waits well past the timeout limit while a scoreboard with an empty queue catches any pulse. Finally it toggles `cycling_off` and expects fresh back-to-back results. A second instance with an 8-bit count reaches saturation within a short window.

// File: rtl/slow_clk_cal.sv
module slow_clk_cal #(
  parameter int CNT_W    = 25,
  parameter int MAX_W    = 15,
  parameter int THR_W    = 22,
  parameter int TO_SHIFT = 4
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [2:0]       slow_clk,
  input  logic [1:0]       src_sel,
  input  logic [MAX_W-1:0] max_cycles,
  input  logic             start_oneshot,
  input  logic             cycling_off,
  input  logic [THR_W-1:0] timeout_thres,
  output logic             cal_ready,
  output logic             cycle_valid,
  output logic             cal_timeout,
  output logic [CNT_W-1:0] cal_value
);
  localparam int TO_W = THR_W + TO_SHIFT + 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;
  st_t st;

  logic             sel_clk;
  logic [2:0]       sync_q;
  logic             os_q, off_q, run_cyc;
  logic [CNT_W-1:0] ref_cnt;
  logic [MAX_W-1:0] edge_cnt;
  logic [TO_W-1:0]  tmo_cnt;

  always_comb begin
    case (src_sel)
      2'd0:    sel_clk = slow_clk[0];
      2'd1:    sel_clk = slow_clk[1];
      2'd2:    sel_clk = slow_clk[2];
      default: sel_clk = 1'b0;
    endcase
  end

  wire slow_edge = sync_q[1] & ~sync_q[2];
  wire cyc_en    = ~cycling_off;
  wire rearm     = off_q & ~cycling_off;
  wire os_start  = start_oneshot & ~os_q & ~cyc_en;
  wire cyc_start = cyc_en & (st == S_IDLE) & (~cal_timeout | rearm);
  wire abort     = run_cyc & ~cyc_en & (st != S_IDLE);
  wire [TO_W-1:0] to_lim = {1'b0, timeout_thres, {TO_SHIFT{1'b0}}};
  wire to_hit   = (st != S_IDLE) && (tmo_cnt >= to_lim);
  wire win_done = (st == S_RUN) && slow_edge &&
                  (({1'b0, edge_cnt} + (MAX_W+1)'(1)) == {1'b0, max_cycles});

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= '0;
      os_q        <= 1'b0;
      off_q       <= 1'b0;
      run_cyc     <= 1'b0;
      st          <= S_IDLE;
      ref_cnt     <= '0;
      edge_cnt    <= '0;
      tmo_cnt     <= '0;
      cal_ready   <= 1'b0;
      cycle_valid <= 1'b0;
      cal_timeout <= 1'b0;
      cal_value   <= '0;
    end else begin
      sync_q      <= {sync_q[1:0], sel_clk};
      os_q        <= start_oneshot;
      off_q       <= cycling_off;
      cycle_valid <= 1'b0;
      if (rearm) cal_timeout <= 1'b0;
      if (os_start || cyc_start) begin
        st          <= S_WAIT;
        run_cyc     <= cyc_start;
        tmo_cnt     <= '0;
        cal_ready   <= 1'b0;
        cal_timeout <= 1'b0;
      end else if (abort) begin
        st <= S_IDLE;
      end else if (st != S_IDLE) begin
        tmo_cnt <= tmo_cnt + TO_W'(1);
        if (win_done) begin
          cal_value <= ref_cnt;
          if (run_cyc) begin
            cycle_valid <= 1'b1;
            ref_cnt     <= CNT_W'(1);
            edge_cnt    <= '0;
            tmo_cnt     <= '0;
          end else begin
            cal_ready <= 1'b1;
            st        <= S_IDLE;
          end
        end else if (to_hit) begin
          cal_timeout <= 1'b1;
          st          <= S_IDLE;
        end else if (st == S_WAIT) begin
          if (slow_edge) begin
            st       <= S_RUN;
            ref_cnt  <= CNT_W'(1);
            edge_cnt <= '0;
          end
        end else begin
          if (ref_cnt != '1) ref_cnt <= ref_cnt + CNT_W'(1);
          if (slow_edge) edge_cnt <= edge_cnt + MAX_W'(1);
        end
      end
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (st == S_RUN) |-> (ref_cnt != '0)); // R10
  AST_VALID_PULSE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cycle_valid |=> !cycle_valid); // R5
  AST_TIMEOUT_STOPS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(cal_timeout) |-> (st == S_IDLE)); // R6
  AST_ZERO_MAX: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ((st == S_RUN) && (max_cycles == '0)) |=> (!cal_ready && !cycle_valid)); // R9
  AST_READY_ONESHOT: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(cal_ready) |-> (!run_cyc && $past(st) == S_RUN)); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(cal_ready && cycle_valid)); // R5
endmodule

// File: tb/slow_clk_cal_tb.sv
`timescale 1ns/100ps
module slow_clk_cal_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  slow_clk = 3'b000;
  logic [1:0]  src_sel = 2'd0;
  logic [14:0] max_cycles = 15'd4;
  logic        start_oneshot = 1'b0;
  logic        cycling_off = 1'b0;
  logic [21:0] timeout_thres = 22'd100;
  logic        cal_ready, cycle_valid, cal_timeout;
  logic [24:0] cal_value;
  logic        s_ready, s_valid, s_timeout;
  logic [7:0]  s_value;

  int checks = 0, errors = 0;
  int exp_q[$];
  logic rdy_q = 1'b0;

  always #2.5 clk = ~clk;
  initial begin #1; forever #25 slow_clk[0] = ~slow_clk[0]; end
  initial begin #1; forever #35 slow_clk[1] = ~slow_clk[1]; end
  initial begin #1; forever #65 slow_clk[2] = ~slow_clk[2]; end

  slow_clk_cal u_dut (.clk_ref(clk), .rst_n(rst_n), .slow_clk(slow_clk), .src_sel(src_sel),
    .max_cycles(max_cycles), .start_oneshot(start_oneshot), .cycling_off(cycling_off),
    .timeout_thres(timeout_thres), .cal_ready(cal_ready), .cycle_valid(cycle_valid),
    .cal_timeout(cal_timeout), .cal_value(cal_value));

  slow_clk_cal #(.CNT_W(8)) u_sat (.clk_ref(clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .src_sel(src_sel), .max_cycles(max_cycles), .start_oneshot(start_oneshot),
    .cycling_off(cycling_off), .timeout_thres(timeout_thres), .cal_ready(s_ready),
    .cycle_valid(s_valid), .cal_timeout(s_timeout), .cal_value(s_value));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (cycle_valid || (cal_ready && !rdy_q))) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected result", int'(cal_value), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(cal_value) == e, "R1 measured value", int'(cal_value), e);
      end
    end
    rdy_q <= cal_ready;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic oneshot(input logic [1:0] sel, input int mx, input int thr, input int exp, input bit push);
    src_sel = sel; max_cycles = 15'(mx); timeout_thres = 22'(thr);
    if (push) exp_q.push_back(exp);
    start_oneshot = 1'b0; cycles(2);
    start_oneshot = 1'b1; cycles(2);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    chk(!cal_ready && !cycle_valid && !cal_timeout && cal_value == 0, "R11 reset state",
        int'(cal_value), 0);
    rst_n = 1'b1;
    // R3 cycling by default, R5 back-to-back windows, R8 source 0 (P=10)
    repeat (3) exp_q.push_back(40);
    drain("R3 cycling results");
    cycling_off = 1'b1;
    cycles(150);
    chk(exp_q.size() == 0, "R5 no pulse while off", exp_q.size(), 0);
    // R8 source 1 (P=14), R2 ready, R4 edge start
    oneshot(2'd1, 3, 100, 42, 1'b1);
    drain("R2 one-shot source 1");
    chk(cal_ready == 1'b1, "R2 ready set", int'(cal_ready), 1);
    cycles(200);
    chk(cal_ready == 1'b1 && cal_value == 42, "R4 held start no restart", int'(cal_value), 42);
    oneshot(2'd2, 2, 100, 52, 1'b1);
    drain("R8 one-shot source 2");
    oneshot(2'd0, 7, 100, 70, 1'b1);
    drain("R1 one-shot source 0");
    // R10 saturation on narrow instance
    oneshot(2'd2, 12, 100, 312, 1'b1);
    drain("R10 wide value");
    chk(s_ready && s_value == 8'hFF, "R10 saturated value", int'(s_value), 255);
    // R9 zero max ends only by timeout (limit 48)
    oneshot(2'd0, 0, 3, 0, 1'b0);
    cycles(20);
    chk(!cal_timeout && !cal_ready, "R6 no early timeout", int'(cal_timeout), 0);
    cycles(80);
    chk(cal_timeout && !cal_ready, "R9 zero max timed out", int'(cal_ready), 0);
    // R6 next measurement unaffected
    oneshot(2'd1, 2, 100, 28, 1'b1);
    drain("R6 after timeout");
    chk(!cal_timeout, "R6 timeout cleared", int'(cal_timeout), 0);
    // R8 select 3 has no source
    oneshot(2'd3, 1, 4, 0, 1'b0);
    cycles(120);
    chk(cal_timeout && !cal_ready, "R8 select 3 timeout", int'(cal_timeout), 1);
    start_oneshot = 1'b0;
    // R7 cycling aborted by short timeout
    src_sel = 2'd0; max_cycles = 15'd1000; timeout_thres = 22'd1;
    cycling_off = 1'b0;
    cycles(60);
    chk(cal_timeout == 1'b1, "R7 cycling timeout", int'(cal_timeout), 1);
    cycles(200);
    chk(cal_timeout == 1'b1 && exp_q.size() == 0, "R7 cycling stays stopped", int'(cal_timeout), 1);
    cycling_off = 1'b1; timeout_thres = 22'd100; max_cycles = 15'd2;
    cycles(3);
    repeat (2) exp_q.push_back(20);
    cycling_off = 1'b0;
    drain("R7 cycling resumes");
    chk(!cal_timeout, "R7 rearm clears timeout", int'(cal_timeout), 0);
    cycling_off = 1'b1;
    cycles(100);
    chk(exp_q.size() == 0, "R5 queue empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule